// File: doc/BRIEF.md
# Reduced-Pin Gigabit Transmit Nibble Encoder

This block sits between a MAC that produces one transmit byte per clock, together with an enable flag and an error flag, and a PHY that expects a four-bit double-data-rate data bus and one control line. Each byte leaves the block as two nibbles. The enable and error flags share the control line, using the same edge multiplexing as the data. The block also forwards its own clock to the PHY as the transmit clock. The data and control outputs are timed only by that forwarded clock.

A speed-select input picks between 1000 Mbps and 10/100 Mbps behaviour. At 1000 Mbps the clock runs at 125 MHz and a byte is accepted on every cycle. At 10 or 100 Mbps the clock runs at 2.5 or 25 MHz. In those modes each nibble is held for a whole clock cycle, so a byte takes two cycles, and a ready output tells the MAC when the next byte is taken. The block does not generate clocks, insert output delays, build frames or manage the PHY.

Top module: `rgmii_tx_nibbler`

## Requirements
- R1: At 1000 Mbps (speed[1] = 1), the byte captured at a rising edge is shown during the following high phase as bits [3:0] and during the following low phase as bits [7:4]. A new byte is taken on every cycle.
- R2: On txd, bit 0 carries the least significant bit of the nibble, so txd[k] equals byte bit k for the low nibble and byte bit k+4 for the high nibble.
- R3: tx_ctl equals the captured enable during the high phase of the clock, and enable XOR error during the low phase.
- R4: While the captured enable is low, txd is 0 in both phases, whatever the data byte holds.
- R5: At 10 or 100 Mbps (speed = 00 or 01), an accepted byte drives bits [3:0] in both phases of the first cycle after capture, and bits [7:4] in both phases of the second cycle.
- R6: mac_ready is always high at 1000 Mbps. At 10/100 Mbps it is high in the cycle that accepts a byte and low in the cycle after. Inputs presented while it is low are ignored.
- R7: Inputs are sampled at a rising edge of clk only when mac_ready is high, and they appear on the outputs in the clock cycle that starts at that edge.
- R8: tx_clk_out follows clk.
- R9: While rst_n is low, txd and tx_ctl are low and mac_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock: 125, 25 or 2.5 MHz depending on speed |
| rst_n | input | 1 | Active-low reset |
| speed | input | 2 | Rate select: 00 = 10 Mbps, 01 = 100 Mbps, 1x = 1000 Mbps |
| mac_data | input | 8 | Transmit byte from the MAC |
| mac_en | input | 1 | Byte is valid frame data |
| mac_err | input | 1 | Byte carries a transmit error |
| mac_ready | output | 1 | Byte inputs are taken at the next rising edge |
| tx_clk_out | output | 1 | Transmit clock forwarded to the PHY |
| txd | output | 4 | Double-data-rate nibble bus |
| tx_ctl | output | 1 | Enable in the high phase, enable XOR error in the low phase |

## Verification
The assertions assume two things about the inputs. The speed select changes only at a byte boundary, when mac_ready is high, and never in the middle of a 10/100 byte pair. The byte inputs change well away from the rising edge. The stimulus meets both by driving every input just after a falling edge, and by switching speed only after a two-cycle pair is complete. During the second cycle of each pair it deliberately presents a different byte and different flags, so that the inputs ignored while not ready show up as an error on the expected high nibble.

// File: rtl/rgmii_tx_nibbler.sv
module rgmii_tx_nibbler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed,
  input  logic [7:0] mac_data,
  input  logic       mac_en,
  input  logic       mac_err,
  output logic       mac_ready,
  output logic       tx_clk_out,
  output logic [3:0] txd,
  output logic       tx_ctl
);

  logic       gig_in;
  logic       gig_q;
  logic       pair_q;
  logic       hi_sel_q;
  logic       en_q;
  logic       er_q;
  logic [7:0] byte_q;
  logic [3:0] nib_rise;
  logic [3:0] nib_fall;
  logic [3:0] nib_slow;

  assign gig_in    = speed[1];
  assign mac_ready = gig_in | ~pair_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gig_q    <= 1'b0;
      pair_q   <= 1'b0;
      hi_sel_q <= 1'b0;
      en_q     <= 1'b0;
      er_q     <= 1'b0;
      byte_q   <= 8'h00;
    end else begin
      hi_sel_q <= ~mac_ready;
      if (mac_ready) begin
        gig_q  <= gig_in;
        pair_q <= ~gig_in;
        en_q   <= mac_en;
        er_q   <= mac_err;
        byte_q <= mac_en ? mac_data : 8'h00;
      end else begin
        pair_q <= 1'b0;
      end
    end
  end

  assign nib_slow   = hi_sel_q ? byte_q[7:4] : byte_q[3:0];
  assign nib_rise   = gig_q ? byte_q[3:0] : nib_slow;
  assign nib_fall   = gig_q ? byte_q[7:4] : nib_slow;

  assign tx_clk_out = clk;
  assign txd        = clk ? nib_rise : nib_fall;
  assign tx_ctl     = clk ? en_q : (en_q ^ er_q);

endmodule

// File: rtl/rgmii_tx_nibbler_chk.sv
module rgmii_tx_nibbler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] speed,
  input logic       mac_ready,
  input logic [3:0] txd,
  input logic       tx_ctl
);

  AST_IDLE_DATA_ZERO: assert property (@(negedge clk) disable iff (!rst_n) !tx_ctl |-> txd == 4'h0); // R4

  AST_GIG_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n) speed[1] |-> mac_ready); // R6

  AST_SLOW_READY_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed[1] && mac_ready) |=> (!mac_ready || !$stable(speed))); // R6

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (txd == 4'h0 && !tx_ctl && mac_ready); // R9
    end
  end

endmodule

bind rgmii_tx_nibbler rgmii_tx_nibbler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .speed(speed), .mac_ready(mac_ready),
  .txd(txd), .tx_ctl(tx_ctl)
);

// File: tb/test_rgmii_tx_nibbler.sv
module test_rgmii_tx_nibbler;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] speed;
  logic [7:0] mac_data;
  logic       mac_en;
  logic       mac_err;
  logic       mac_ready;
  logic       tx_clk_out;
  logic [3:0] txd;
  logic       tx_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] h_nib;
    logic       h_ctl;
    logic [3:0] l_nib;
    logic       l_ctl;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  rgmii_tx_nibbler i_rgmii_tx_nibbler (
    .clk(clk), .rst_n(rst_n), .speed(speed), .mac_data(mac_data),
    .mac_en(mac_en), .mac_err(mac_err), .mac_ready(mac_ready),
    .tx_clk_out(tx_clk_out), .txd(txd), .tx_ctl(tx_ctl)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [1:0] spd, input logic [7:0] d, input logic en, input logic er);
    @(negedge clk);
    #1;
    speed = spd; mac_data = d; mac_en = en; mac_err = er;
    #1;
  endtask

  task automatic send_gig(input logic [1:0] spd, input logic [7:0] d, input logic en, input logic er);
    exp_t e;
    drive(spd, d, en, er);
    check("R6 gigabit ready", {7'd0, mac_ready}, 8'd1);
    e.h_nib = en ? d[3:0] : 4'h0;
    e.l_nib = en ? d[7:4] : 4'h0;
    e.h_ctl = en;
    e.l_ctl = en ^ er;
    e.tag   = "R1 R2 R3 R4 R7";
    q.push_back(e);
  endtask

  task automatic send_slow(input logic [1:0] spd, input logic [7:0] d, input logic en, input logic er);
    exp_t e;
    drive(spd, d, en, er);
    check("R6 slow ready first", {7'd0, mac_ready}, 8'd1);
    e.h_nib = en ? d[3:0] : 4'h0;
    e.l_nib = e.h_nib;
    e.h_ctl = en;
    e.l_ctl = en ^ er;
    e.tag   = "R5 R2 R3 R4 R7";
    q.push_back(e);
    drive(spd, ~d, ~en, ~er);
    check("R6 slow ready second", {7'd0, mac_ready}, 8'd0);
    e.h_nib = en ? d[7:4] : 4'h0;
    e.l_nib = e.h_nib;
    e.tag   = "R5 R6 ignored inputs";
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " high txd"}, {4'd0, txd}, {4'd0, e.h_nib});
        check({e.tag, " high ctl"}, {7'd0, tx_ctl}, {7'd0, e.h_ctl});
        check("R8 clock high", {7'd0, tx_clk_out}, 8'd1);
        #10;
        check({e.tag, " low txd"}, {4'd0, txd}, {4'd0, e.l_nib});
        check({e.tag, " low ctl"}, {7'd0, tx_ctl}, {7'd0, e.l_ctl});
        check("R8 clock low", {7'd0, tx_clk_out}, 8'd0);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0;
    speed = 2'b10; mac_data = 8'hFF; mac_en = 1'b1; mac_err = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #5;
      check("R9 reset txd high", {4'd0, txd}, 8'd0);
      check("R9 reset ctl high", {7'd0, tx_ctl}, 8'd0);
      check("R9 reset ready", {7'd0, mac_ready}, 8'd1);
      #10;
      check("R9 reset txd low", {4'd0, txd}, 8'd0);
      check("R9 reset ctl low", {7'd0, tx_ctl}, 8'd0);
    end
    @(negedge clk);
    #1;
    mac_en = 1'b0; mac_err = 1'b0; mac_data = 8'h00;
    rst_n = 1'b1;
    @(negedge clk);

    send_gig(2'b10, 8'hA5, 1'b1, 1'b0);
    send_gig(2'b10, 8'h3C, 1'b1, 1'b1);
    send_gig(2'b10, 8'h00, 1'b0, 1'b0);
    send_gig(2'b10, 8'h7E, 1'b0, 1'b1);
    send_gig(2'b10, 8'hF0, 1'b1, 1'b0);
    send_gig(2'b11, 8'h81, 1'b1, 1'b0);
    send_gig(2'b11, 8'h69, 1'b1, 1'b0);

    send_slow(2'b01, 8'h5A, 1'b1, 1'b0);
    send_slow(2'b01, 8'hC3, 1'b1, 1'b1);
    send_slow(2'b01, 8'hE7, 1'b0, 1'b0);
    send_slow(2'b00, 8'h96, 1'b1, 1'b0);
    send_slow(2'b00, 8'h4B, 1'b1, 1'b0);

    send_gig(2'b10, 8'h12, 1'b1, 1'b0);
    send_gig(2'b10, 8'hDB, 1'b0, 1'b0);

    drive(2'b10, 8'h00, 1'b0, 1'b0);
    repeat (4) @(posedge clk);
    #20;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule